// File: doc/BRIEF.md
# Flag-Setting 32-bit Data-Processing ALU

This block is the execute-stage arithmetic and logic unit of a 32-bit integer core. Each cycle it takes a 4-bit operation code, a first operand and an already shifted second operand. It also takes the carry-out of the barrel shifter, with a bit saying whether that carry is meaningful, and a set-flags enable. It produces the 32-bit result, a write-enable for that result and the next value of the four condition flags: negative, zero, carry and overflow.

The sixteen operations cover several groups:
- bitwise logic: AND, EOR, ORR, BIC, MOV and MVN;
- addition with and without carry-in: ADD and ADC;
- subtraction in both operand orders, with and without carry-in: SUB, RSB, SBC and RSC;
- four test and compare operations that only affect the flags: TST, TEQ, CMP and CMN.

The flags are held in a clocked register inside the block. That register supplies the carry-in for the carry-using operations. It is shown to the rest of the core as the top nibble of a 32-bit status word. Subtraction reports carry as the inverse of borrow. Logic operations leave overflow alone and take carry from the shifter.

Top module: `dp_alu_core`

## Requirements
- R1: Operation codes decode as 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, A CMP, B CMN, C ORR, D MOV, E BIC (first AND NOT second), F MVN (NOT second); for every code `result` carries the computed value.
- R2: ADD and CMN compute first + second, and ADC adds the stored carry flag as well; the carry flag becomes the carry out of bit 31.
- R3: SUB and CMP compute first − second, and RSB computes second − first; the carry flag is 1 exactly when no borrow occurs.
- R4: SBC computes first − second − 1 and RSC computes second − first − 1 when the stored carry is 0; with a stored carry of 1 each drops the extra one. Carry is again the inverse of borrow.
- R5: `result_we` is 0 for codes 8 to B and 1 for all other codes.
- R6: For logic codes (0, 1, 8, 9, C, D, E, F), overflow keeps its stored value. Carry takes `shf_carry` when `shf_carry_vld` is 1 and keeps its stored value otherwise.
- R7: For additions, overflow is set when both addends have the same sign and the sum's sign differs from it. For subtractions, it is set when the minuend and subtrahend signs differ and the result's sign differs from the minuend's.
- R8: While `set_flags` is 0, `flags_next` equals the stored flags and the register holds its value across the clock edge.
- R9: While `set_flags` is 1, the register loads `flags_next` at the rising edge. `stat_word` carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28, and zeros elsewhere; `flags_next` is ordered {N,Z,C,V} from bit 3 down to bit 0.
- R10: A synchronous active-high `rst` clears all four stored flags to 0.
- R11: For every flag-setting operation, N equals bit 31 of `result` and Z is 1 exactly when `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_code | input | 4 | Data-processing operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Shifted second operand |
| shf_carry | input | 1 | Carry-out of the shifter |
| shf_carry_vld | input | 1 | Shifter carry-out is meaningful |
| set_flags | input | 1 | Update the flags with this operation |
| result | output | 32 | Computed result |
| result_we | output | 1 | Result is to be written back |
| flags_next | output | 4 | Next flag values {N,Z,C,V} |
| stat_word | output | 32 | Stored flags placed in bits 31 to 28 |

## Verification
On every cycle, the assertions check several relations:
- the flag register holding when flag setting is off, and loading the offered flags when it is on;
- reset clearing the flags;
- compare and test codes never raising the write-enable;
- Z tracking a zero result;
- overflow surviving any logic operation.

The arithmetic itself can only be shown by the bench's scenarios. These cover carry as inverted borrow, the reversed operand order, the extra one subtracted when carry is clear, signed overflow at both ends of the range, and the choice between shifter carry and kept carry. The bench preloads a known carry before each case.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W  = 32;
    localparam int FLAG_W  = 4;

    typedef enum logic [3:0] {
        OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
        OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
        OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
        OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Operations that compute through the adder
    function automatic logic op_is_arith(alu_op_e op);
        case (op)
            OP_SUB, OP_RSB, OP_ADD, OP_ADC,
            OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

    // Operations whose result is discarded
    function automatic logic op_is_probe(alu_op_e op);
        case (op)
            OP_TST, OP_TEQ, OP_CMP, OP_CMN: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);

    always_comb begin
        case (op)
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  alu_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            cin,
    output logic [DW-1:0]   sum,
    output logic            cout,
    output logic            ovf
);

    localparam int MSB = DW - 1;

    logic [DW-1:0] x, y;
    logic          ci;
    logic [DW:0]   wide;

    // Subtraction is x + ~y + carry, so carry-out means no borrow
    always_comb begin
        case (op)
            OP_ADD, OP_CMN: begin x = a; y = b;  ci = 1'b0; end
            OP_ADC:         begin x = a; y = b;  ci = cin;  end
            OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1; end
            OP_SBC:         begin x = a; y = ~b; ci = cin;  end
            OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
            OP_RSC:         begin x = b; y = ~a; ci = cin;  end
            default:        begin x = '0; y = '0; ci = 1'b0; end
        endcase
    end

    assign wide = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    assign sum  = wide[MSB:0];
    assign cout = wide[DW];
    assign ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R10: reset clears the stored flags
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R8: register holds without a load
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    // R9: register takes the offered value on a load
    a_r9_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import alu_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    input  logic              shf_carry,
    input  logic              shf_carry_vld,
    input  logic              set_flags,
    output logic [DW-1:0]     result,
    output logic              result_we,
    output logic [FLAG_W-1:0] flags_next,
    output logic [STAT_W-1:0] stat_word
);

    localparam int MSB = DW - 1;

    alu_op_e       op;
    flags_t        fl_q, fl_calc, fl_d;
    logic [DW-1:0] logic_y, arith_y;
    logic          arith_c, arith_v, is_arith;

    assign op       = alu_op_e'(op_code);
    assign is_arith = op_is_arith(op);

    alu_logic_unit #(.DW(DW)) u_logic (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    alu_arith_unit #(.DW(DW)) u_arith (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .cin  (fl_q.c),
        .sum  (arith_y),
        .cout (arith_c),
        .ovf  (arith_v)
    );

    assign result    = is_arith ? arith_y : logic_y;
    assign result_we = !op_is_probe(op);

    always_comb begin
        fl_calc.n = result[MSB];
        fl_calc.z = (result == '0);
        if (is_arith) begin
            fl_calc.c = arith_c;
            fl_calc.v = arith_v;
        end else begin
            fl_calc.c = shf_carry_vld ? shf_carry : fl_q.c;
            fl_calc.v = fl_q.v;
        end
    end

    assign fl_d       = set_flags ? fl_calc : fl_q;
    assign flags_next = fl_d;

    alu_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (set_flags),
        .d    (fl_d),
        .q    (fl_q)
    );

    assign stat_word = {fl_q, {(STAT_W-FLAG_W){1'b0}}};

    // R5: test and compare codes never request a write-back
    a_r5_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_code[3:2] == 2'b10) |-> !result_we);

    // R11: offered Z tracks a zero result
    a_r11_zero_flag: assert property (@(posedge clk) disable iff (rst)
        set_flags |-> (flags_next[2] == (result == '0)));

    // R6: logic operations keep overflow
    a_r6_keep_v: assert property (@(posedge clk) disable iff (rst)
        (set_flags && !is_arith) |-> (flags_next[0] == stat_word[STAT_W-4]));

endmodule

// File: tb/tb_dp_alu_core.sv
`timescale 1ns/1ps
module tb_dp_alu_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic        shf_carry, shf_carry_vld, set_flags;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags_next;
    logic [31:0] stat_word;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    dp_alu_core dut (
        .clk(clk), .rst(rst), .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shf_carry(shf_carry), .shf_carry_vld(shf_carry_vld), .set_flags(set_flags),
        .result(result), .result_we(result_we), .flags_next(flags_next),
        .stat_word(stat_word)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic        shc;
        logic        shv;
        logic        pre_c;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{4'h0, 32'hF0F0_FF00, 32'hFF00_0FF0, 1'b1, 1'b1, 1'b0, 32'hF000_0F00, 1'b1, 4'b1010},
        '{4'h1, 32'hFFFF_0000, 32'hFFFF_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 4'b0110},
        '{4'hC, 32'h0000_00F0, 32'h8000_000F, 1'b0, 1'b1, 1'b1, 32'h8000_00FF, 1'b1, 4'b1000},
        '{4'hE, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0, 32'hFFFF_0000, 1'b1, 4'b1000},
        '{4'hD, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 4'b0110},
        '{4'hF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'b1000},
        '{4'h4, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 4'b0110},
        '{4'h4, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 4'b1001},
        '{4'h5, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b0, 1'b1, 32'h0000_0004, 1'b1, 4'b0000},
        '{4'h5, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 4'b0110},
        '{4'h2, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 32'h0000_0002, 1'b1, 4'b0010},
        '{4'h2, 32'h0000_0003, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE, 1'b1, 4'b1000},
        '{4'h2, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 1'b1, 4'b0011},
        '{4'h3, 32'h0000_0003, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 32'h0000_0002, 1'b1, 4'b0010},
        '{4'h6, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 32'h0000_0001, 1'b1, 4'b0010},
        '{4'h6, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 4'b1000},
        '{4'h7, 32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 4'b0110},
        '{4'h7, 32'h0000_0004, 32'h0000_0003, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE, 1'b1, 4'b1000},
        '{4'h8, 32'h0000_00F0, 32'h0000_000F, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 4'b0110},
        '{4'h9, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 1'b0, 4'b1000},
        '{4'hA, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'b0110},
        '{4'hB, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 4'b0111}
    };

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'h0, 4'h1, 4'hC, 4'hD, 4'hE, 4'hF: return "R1/R6";
            4'h4, 4'h5:                         return "R2/R7";
            4'h2, 4'h3:                         return "R3/R7";
            4'h6, 4'h7:                         return "R4";
            default:                            return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic shc, logic shv, logic set);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b;
        shf_carry = shc; shf_carry_vld = shv; set_flags = set;
    endtask

    // Load a known flag state: CMP 0,0 gives 0110, ADD 0,0 gives 0100
    task automatic preset(logic c);
        drive(c ? 4'hA : 4'h4, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_code = 4'h0; opnd_a = '0; opnd_b = '0;
        shf_carry = 1'b0; shf_carry_vld = 1'b0; set_flags = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: flags cleared after reset
        check("R10 reset status word", stat_word, 32'h0);

        for (int i = 0; i < NV; i++) begin
            preset(VEC[i].pre_c);
            drive(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].shc, VEC[i].shv, 1'b1);
            #1;
            check({req_of(VEC[i].op), " result"},   VEC[i].res, VEC[i].res == result ? VEC[i].res : result ^ 32'h0 ^ (result ^ VEC[i].res) ^ (result ^ VEC[i].res) ? result : result);
            check({req_of(VEC[i].op), " result"},   result, VEC[i].res);
            check({req_of(VEC[i].op), " R5 write enable"}, {31'h0, result_we}, {31'h0, VEC[i].we});
            check({req_of(VEC[i].op), " R11 flags_next"}, {28'h0, flags_next}, {28'h0, VEC[i].fl});
            @(negedge clk);
            // R9: stored flags appear at bits 31..28
            check("R9 stat_word after load", stat_word, {VEC[i].fl, 28'h0});
        end

        // R6: logic op keeps V=1 and C=0 when shifter carry is not valid
        drive(4'h4, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 1'b1);
        drive(4'h0, 32'h1, 32'h1, 1'b1, 1'b0, 1'b1);
        #1;
        check("R6 logic keeps V and C", {28'h0, flags_next}, {28'h0, 4'b0001});
        @(negedge clk);
        check("R6 stored after logic op", stat_word, {4'b0001, 28'h0});

        // R8: set_flags low holds the register and offers the stored flags
        drive(4'h2, 32'h3, 32'h5, 1'b0, 1'b0, 1'b0);
        #1;
        check("R8 result still computed", result, 32'hFFFF_FFFE);
        check("R8 flags_next equals stored", {28'h0, flags_next}, {28'h0, 4'b0001});
        @(negedge clk);
        check("R8 stat_word unchanged", stat_word, {4'b0001, 28'h0});

        // R10: reset in mid-run clears a non-zero flag state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid-run reset", stat_word, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule